// File: doc/BRIEF.md
# IDCT Row Stage with Pixel Clamp

This block is the second half of a two-pass 8x8 inverse DCT. The first pass has already dequantized and transformed the columns. This block takes one row of eight signed 32-bit intermediate values per handshake and runs the scaled 8-point butterfly network on it. The network uses four fixed 16-bit rotation constants, and each multiply keeps the upper 32 bits of a 32x16 product. The row stage does no dequantizing.

Before the butterflies, the DC input gets one constant added to it. That constant carries the +128 level shift in the upper half and a half-LSB rounding term at bit 15. Each of the eight results is then reduced to its upper 16 bits, read as a signed number, and clamped to an unsigned byte. The eight bytes leave as one 64-bit word. A mode input selects the byte order inside each 32-bit half of that word, so a downstream writer can store it in either memory order.

Rows are numbered 0 to 7 in the order they are accepted. The row number travels with the data, and the block flags the last row of each 8x8 block. There are two register stages. A stalled output holds the whole pipeline.

Top module: `idct_row_stage`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1, and the first row accepted afterwards carries row index 0.
- R2: A row whose only nonzero input is lane 0 (value d) produces eight equal pixels, each equal to the clamp of bits [31:16] of d + 0x00808000. So d = 0 gives 128, d = 0x7FFF gives 128 and d = 0x8000 gives 129.
- R3: For a general row x0..x7, each pixel equals the clamp of the upper half of the result of the scaled butterfly network. The network's four multiplies are floor((v*c)/65536), with c = 27146, 15137, -21407 and -8867. In the even part, 27146 is applied to x2 - x6 and the product is added back. In the odd part, 27146 is applied to (x1+x7) - (x3+x5) and added back. The 15137 term scales the sum of the two odd differences. The terms -21407 and -8867 scale x5 - x3 and x1 - x7, and each is then multiplied by 8.
- R4: Clamping reads bits [31:16] as signed 16-bit. A negative value gives 0, a value above 255 gives 255, and any other value passes unchanged.
- R5: With `big_endian` = 0, pixel k occupies `out_pixels[8k+7:8k]`.
- R6: With `big_endian` = 1, the bytes inside each 32-bit half are reversed. Pixel k then occupies byte (k & 4) + 3 - (k & 3). The mode is sampled when a row moves into the output stage.
- R7: When `out_ready` stays high, a row accepted at a clock edge is presented on `out_valid` after the second edge that follows it.
- R8: While `out_valid` = 1 and `out_ready` = 0, `in_ready` is 0, and `out_pixels` and `out_row` hold their values on the next edge.
- R9: Output rows appear in acceptance order, and their index advances by one per delivered row, wrapping from 7 to 0.
- R10: `block_done` is 1 exactly when `out_valid` = 1 and `out_row` = 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input row offered |
| in_ready | output | 1 | Row accepted this cycle when high together with in_valid |
| in_coefs | input | 256 | Eight signed 32-bit values, lane k at bits [32k+31:32k] |
| big_endian | input | 1 | Byte order select for each 32-bit half of the output |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Downstream takes the word |
| out_pixels | output | 64 | Eight packed clamped pixels |
| out_row | output | 3 | Row index within the 8x8 block |
| block_done | output | 1 | Last row of a block is on the output |

## Verification
A new row can be offered in the same cycle that the output is stalled. A row can also enter while the block's last row is being delivered. Random `out_ready` and random `in_valid` create both overlaps many times. The bench counts acceptances and deliveries itself, so every delivered word is compared with its expected pixels and expected row index. A held word must keep its value until it is taken, and no row may be accepted while the output is stalled. A row accepted during the cycle that delivers row 7 must come out as row 0 of the next block, with `block_done` low.

// File: rtl/idct_row_pkg.sv
package idct_row_pkg;

    localparam int COEF_W     = 32;
    localparam int LANES      = 8;
    localparam int PIX_W      = 8;
    localparam int HALF_W     = COEF_W / 2;
    localparam int KC_W       = 16;
    localparam int MUL_W      = COEF_W + KC_W;
    localparam int IDX_W      = $clog2(LANES);
    localparam int ROW_W      = COEF_W * LANES;
    localparam int OUT_W      = PIX_W * LANES;
    localparam int WORD_LANES = 4;
    localparam int PIX_MAX    = (1 << PIX_W) - 1;

    typedef logic signed [COEF_W-1:0] word_t;
    typedef logic signed [KC_W-1:0]   kc_t;

    // DC bias: +128 in the upper half, +0.5 LSB at bit 15
    localparam word_t DC_BIAS = word_t'((128 << HALF_W) + (1 << (HALF_W - 1)));

    localparam kc_t K_ROOT2 = 16'sd27146;
    localparam kc_t K_ROT   = 16'sd15137;
    localparam kc_t K_ODD5  = -16'sd21407;
    localparam kc_t K_ODD7  = -16'sd8867;

    // Values handed from the front half to the back half of the network
    typedef struct packed {
        word_t ev_sum;   // biased x0 + x4
        word_t ev_pair;  // x2 + x6
        word_t ev_dif;   // biased x0 - x4
        word_t ev_rot;   // rotated (x2 - x6)
        word_t od_rot;   // shared odd rotation term
        word_t od_mid;   // rotated odd difference
        word_t od_all;   // x1 + x7 + x3 + x5
        word_t od_d5;    // x5 - x3
        word_t od_d7;    // x1 - x7
    } mid_t;

    // Upper COEF_W bits of a COEF_W x KC_W signed product
    function automatic word_t mul_hi(word_t a, kc_t c);
        logic signed [MUL_W-1:0] p;
        p = MUL_W'(a) * MUL_W'(c);
        return COEF_W'(p >>> KC_W);
    endfunction

    // Upper half as signed value, saturated to an unsigned pixel
    function automatic logic [PIX_W-1:0] clamp_pix(word_t v);
        word_t hi;
        hi = v >>> HALF_W;
        if (hi < 0)
            return '0;
        else if (hi > PIX_MAX)
            return '1;
        else
            return PIX_W'(hi);
    endfunction

endpackage

// File: rtl/idct_row_front.sv
module idct_row_front
    import idct_row_pkg::*;
(
    input  logic [ROW_W-1:0] coefs,
    output mid_t             mid
);

    word_t x [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_unpack
        assign x[g] = coefs[g*COEF_W +: COEF_W];
    end

    word_t biased, ev_a, ev_b, ev_c, ev_d;
    word_t od_a, od_b, od_7, od_1, od_5, od_3, od_8;

    always_comb begin
        biased = x[0] + DC_BIAS;
        // even half
        ev_a = biased + x[4];
        ev_b = x[6] + x[2];
        ev_c = ev_a - (x[4] <<< 1);
        ev_d = (x[2] <<< 1) - ev_b;
        // odd half
        od_a = x[1] + x[7];
        od_b = x[3] + x[5];
        od_7 = od_a - (x[7] <<< 1);
        od_1 = od_a - od_b;
        od_5 = (x[5] <<< 1) - od_b;
        od_3 = od_a + od_b;
        od_8 = od_5 + od_7;

        mid.ev_sum  = ev_a;
        mid.ev_pair = ev_b;
        mid.ev_dif  = ev_c;
        mid.ev_rot  = mul_hi(ev_d, K_ROOT2) + ev_d;
        mid.od_rot  = mul_hi(od_8, K_ROT);
        mid.od_mid  = mul_hi(od_1, K_ROOT2) + od_1;
        mid.od_all  = od_3;
        mid.od_d5   = od_5;
        mid.od_d7   = od_7;
    end

endmodule

// File: rtl/idct_row_back.sv
module idct_row_back
    import idct_row_pkg::*;
(
    input  mid_t             mid,
    output logic [ROW_W-1:0] res
);

    word_t f0, f2, f6, g5, g8;
    word_t h0, h2, h4;
    word_t k1, k3, k4, k5, k7, k7b;
    word_t y [LANES];

    always_comb begin
        f0 = mid.ev_sum + mid.ev_pair;
        f2 = mid.ev_rot - mid.ev_pair;
        f6 = mid.ev_sum - mid.ev_pair;

        g5 = mul_hi(mid.od_d5, K_ODD5) + mid.od_rot;
        g8 = mul_hi(mid.od_d7, K_ODD7) + mid.od_rot;

        h4 = mid.ev_dif + f2;
        h0 = f0 + mid.od_all;
        h2 = mid.ev_dif - f2;

        k7  = (g5 <<< 3) - mid.od_all;
        k3  = f0 - mid.od_all;
        k1  = mid.od_mid - k7;
        k4  = h4 + k7;
        k5  = (g8 <<< 3) - k1;
        k7b = h4 - k7;

        // output lane mapping of the network
        y[0] = h0;
        y[1] = k4;
        y[2] = h2 + k1;
        y[3] = f6 + k5;
        y[4] = f6 - k5;
        y[5] = h2 - k1;
        y[6] = k7b;
        y[7] = k3;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_flat
        assign res[g*COEF_W +: COEF_W] = y[g];
    end

endmodule

// File: rtl/idct_row_pack.sv
module idct_row_pack
    import idct_row_pkg::*;
(
    input  logic [ROW_W-1:0] res,
    input  logic             big_endian,
    output logic [OUT_W-1:0] pix
);

    logic [OUT_W-1:0] pix_le, pix_be;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam int BASE = (g / WORD_LANES) * WORD_LANES;
        localparam int SWAP = BASE + (WORD_LANES - 1) - (g % WORD_LANES);
        logic [PIX_W-1:0] p;
        assign p = clamp_pix(res[g*COEF_W +: COEF_W]);
        assign pix_le[g*PIX_W    +: PIX_W] = p;
        assign pix_be[SWAP*PIX_W +: PIX_W] = p;
    end

    assign pix = big_endian ? pix_be : pix_le;

endmodule

// File: rtl/idct_row_stage.sv
module idct_row_stage
    import idct_row_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [ROW_W-1:0] in_coefs,
    input  logic             big_endian,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [OUT_W-1:0] out_pixels,
    output logic [IDX_W-1:0] out_row,
    output logic             block_done
);

    localparam logic [IDX_W-1:0] LAST_ROW = IDX_W'(LANES - 1);

    logic             advance;
    logic             va_q, vb_q;
    logic [IDX_W-1:0] acc_row_q, row_a_q, row_b_q;
    mid_t             mid_d, mid_q;
    logic [ROW_W-1:0] res_d;
    logic [OUT_W-1:0] pix_d, pix_q;

    idct_row_front u_front (
        .coefs (in_coefs),
        .mid   (mid_d)
    );

    idct_row_back u_back (
        .mid (mid_q),
        .res (res_d)
    );

    idct_row_pack u_pack (
        .res        (res_d),
        .big_endian (big_endian),
        .pix        (pix_d)
    );

    assign advance  = !vb_q || out_ready;
    assign in_ready = advance;

    always_ff @(posedge clk) begin
        if (rst) begin
            va_q      <= 1'b0;
            vb_q      <= 1'b0;
            acc_row_q <= '0;
            row_a_q   <= '0;
            row_b_q   <= '0;
            mid_q     <= '0;
            pix_q     <= '0;
        end else if (advance) begin
            va_q    <= in_valid;
            vb_q    <= va_q;
            row_a_q <= acc_row_q;
            row_b_q <= row_a_q;
            mid_q   <= mid_d;
            pix_q   <= pix_d;
            if (in_valid)
                acc_row_q <= acc_row_q + 1'b1;
        end
    end

    assign out_valid  = vb_q;
    assign out_pixels = pix_q;
    assign out_row    = row_b_q;
    assign block_done = vb_q && (row_b_q == LAST_ROW);

endmodule

// File: rtl/idct_row_stage_chk.sv
module idct_row_stage_chk
    import idct_row_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [OUT_W-1:0] out_pixels,
    input logic [IDX_W-1:0] out_row,
    input logic             block_done
);

    logic             seen_q;
    logic [IDX_W-1:0] last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q <= 1'b0;
            last_q <= '0;
        end else if (out_valid && out_ready) begin
            seen_q <= 1'b1;
            last_q <= out_row;
        end
    end

    // R1
    a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && in_ready));

    // R7
    a_r7_two_edge_latency: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && out_ready) ##1 out_ready |=> out_valid);

    // R8
    a_r8_stall_holds: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_pixels) && $stable(out_row)));

    a_r8_stall_blocks_input: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |-> !in_ready);

    // R9
    a_r9_row_sequence: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && seen_q) |-> (out_row == IDX_W'(last_q + 1'b1)));

    // R10
    a_r10_done_marks_last: assert property (@(posedge clk) disable iff (rst)
        block_done |-> (out_valid && out_row == IDX_W'(LANES - 1)));

    a_r10_last_has_done: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_row == IDX_W'(LANES - 1)) |-> block_done);

endmodule

bind idct_row_stage idct_row_stage_chk chk_i (.*);

// File: tb/idct_row_stage_tb_top.sv
`timescale 1ns/1ps
module idct_row_stage_tb_top;

    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic         in_ready;
    logic [255:0] in_coefs;
    logic         big_endian;
    logic         out_valid;
    logic         out_ready;
    logic [63:0]  out_pixels;
    logic [2:0]   out_row;
    logic         block_done;

    always #4 clk = ~clk;

    idct_row_stage dut_i (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_coefs   (in_coefs),
        .big_endian (big_endian),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .out_pixels (out_pixels),
        .out_row    (out_row),
        .block_done (block_done)
    );

    typedef struct {
        logic [255:0] c;
        int           row;
        int           cyc;
        string        tag;
    } exp_t;

    logic [255:0] src_q [$];
    string        tag_q [$];
    exp_t         exp_q [$];

    int    n_checks = 0;
    int    n_fail   = 0;
    int    cyc      = 0;
    int    acc_row  = 0;
    bit    held     = 0;
    bit    done     = 0;
    logic [63:0] held_pix;

    task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic longint mw(longint v, longint k);
        return (v * k) >>> 16;
    endfunction

    // Reference model written from the requirements
    function automatic logic [63:0] model(logic [255:0] c, bit be);
        longint x [8];
        longint p [8];
        longint b, s0, s4, s6, s2, t2, u0, u2, u6, e1, e2;
        longint a, bb, d7, d1, d5, d3, m8, m1, g5, g8, q7, q1, q5;
        logic [63:0] w;
        for (int k = 0; k < 8; k++) x[k] = longint'($signed(c[k*32 +: 32]));
        b  = x[0] + 64'h0080_8000;
        s0 = b + x[4];
        s4 = b - x[4];
        s6 = x[6] + x[2];
        s2 = x[2] - x[6];
        t2 = mw(s2, 27146) + s2;
        u0 = s0 + s6;
        u2 = t2 - s6;
        u6 = s0 - s6;
        e1 = s4 + u2;
        e2 = s4 - u2;
        a  = x[1] + x[7];
        bb = x[3] + x[5];
        d7 = x[1] - x[7];
        d1 = a - bb;
        d5 = x[5] - x[3];
        d3 = a + bb;
        m8 = mw(d5 + d7, 15137);
        m1 = mw(d1, 27146) + d1;
        g5 = mw(d5, -21407) + m8;
        g8 = mw(d7, -8867) + m8;
        q7 = 8 * g5 - d3;
        q1 = m1 - q7;
        q5 = 8 * g8 - q1;
        p[0] = u0 + d3;  p[7] = u0 - d3;
        p[1] = e1 + q7;  p[6] = e1 - q7;
        p[2] = e2 + q1;  p[5] = e2 - q1;
        p[3] = u6 + q5;  p[4] = u6 - q5;
        w = '0;
        for (int k = 0; k < 8; k++) begin
            int r, hi, slot;
            logic [7:0] px;
            r  = int'(p[k]);
            hi = r >>> 16;
            px = (hi < 0) ? 8'd0 : (hi > 255) ? 8'd255 : 8'(hi);
            slot = be ? ((k / 4) * 4 + 3 - (k % 4)) : k;
            w[slot*8 +: 8] = px;
        end
        return w;
    endfunction

    function automatic logic [255:0] dc_row(logic [31:0] d);
        logic [255:0] c;
        c = '0;
        c[31:0] = d;
        return c;
    endfunction

    function automatic logic [255:0] rand_row();
        logic [255:0] c;
        int sh;
        sh = 9 + 2 * int'($urandom_range(0, 3));
        for (int k = 0; k < 8; k++) c[k*32 +: 32] = 32'($signed($urandom) >>> sh);
        return c;
    endfunction

    task automatic push(logic [255:0] c, string tag);
        src_q.push_back(c);
        tag_q.push_back(tag);
    endtask

    task automatic step(bit rnd_valid, bit rnd_ready);
        exp_t e;
        logic [63:0] want;
        @(negedge clk);
        in_valid  = (src_q.size() > 0) && (!rnd_valid || $urandom_range(0, 3) != 0);
        in_coefs  = (src_q.size() > 0) ? src_q[0] : '0;
        out_ready = !rnd_ready || ($urandom_range(0, 2) != 0);
        #3;
        cyc++;
        if (held)
            check(out_valid && out_pixels == held_pix, "R8", "held word", out_pixels, held_pix);
        held = 0;
        if (out_valid && !out_ready) begin
            check(!in_ready, "R8", "in_ready during stall", 64'(in_ready), 64'd0);
            held     = 1;
            held_pix = out_pixels;
        end
        if (out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
                check(0, "R9", "unexpected output", 64'(out_row), 64'd0);
            end else begin
                e    = exp_q.pop_front();
                want = model(e.c, big_endian);
                check(out_pixels == want, e.tag, "pixels", out_pixels, want);
                check(int'(out_row) == e.row, "R9", "row index", 64'(out_row), 64'(e.row));
                check(block_done == (e.row == 7), "R10", "block_done", 64'(block_done), 64'(e.row == 7));
                if (!rnd_ready)
                    check(cyc - e.cyc == 2, "R7", "latency", 64'(cyc - e.cyc), 64'd2);
            end
        end
        if (in_valid && in_ready) begin
            e.c   = src_q.pop_front();
            e.tag = tag_q.pop_front();
            e.row = acc_row;
            e.cyc = cyc;
            exp_q.push_back(e);
            acc_row = (acc_row + 1) % 8;
        end
    endtask

    task automatic drain(bit rnd_valid, bit rnd_ready);
        for (int i = 0; i < 4000 && (src_q.size() > 0 || exp_q.size() > 0); i++)
            step(rnd_valid, rnd_ready);
        check(src_q.size() == 0 && exp_q.size() == 0, "R9", "drain", 64'(exp_q.size()), 64'd0);
    endtask

    initial begin
        void'($urandom(32'h5eed_1d47));
        rst        = 1'b1;
        in_valid   = 1'b0;
        in_coefs   = '0;
        big_endian = 1'b0;
        out_ready  = 1'b1;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #3;
        check(!out_valid, "R1", "out_valid after reset", 64'(out_valid), 64'd0);
        check(in_ready, "R1", "in_ready after reset", 64'(in_ready), 64'd1);

        // DC rows, bias and rounding
        push(dc_row(32'h0000_0000), "R2");
        push(dc_row(32'h0000_7FFF), "R2");
        push(dc_row(32'h0000_8000), "R2");
        // clamp boundaries
        push(dc_row(32'h007F_0000), "R4");
        push(dc_row(32'h0080_0000), "R4");
        push(dc_row(32'h7F00_0000), "R4");
        push(dc_row(32'hF000_0000), "R4");
        push(dc_row(32'hFF7F_8000), "R4");
        push(dc_row(32'hFF7F_7FFF), "R4");
        drain(0, 0);

        // full network, little-endian, free-running output
        for (int i = 0; i < 40; i++) push(rand_row(), "R5");
        drain(1, 0);

        // backpressure and block boundaries
        for (int i = 0; i < 60; i++) push(rand_row(), "R3");
        drain(1, 1);

        // byte-swapped mode
        big_endian = 1'b1;
        push(dc_row(32'h0000_8000), "R6");
        for (int i = 0; i < 40; i++) push(rand_row(), "R6");
        drain(1, 1);
        big_endian = 1'b0;

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule